// File: doc/BRIEF.md
# Shared Bus Priority Controller

This block owns a single shared bus that connects several processor masters to several slaves, such as memory banks or peer units. Only one transfer can use the bus at any time. A master raises its request line and waits. When the bus is idle, the controller grants it to the requester with the lowest index. The master keeps the grant until it lowers its request. While it owns the bus, its address, command and write data are routed onto the shared lines.

The upper two address bits pick a slave, and only that slave's select line rises. A transfer completes when the selected slave returns its response, and the response is forwarded to the owning master. Some slave slots can be left unpopulated. A transfer that gets no answer, because its address points at an empty slot or because a slave stays silent, ends with an error after a fixed wait so that the bus is freed. The owning master then drops its request. The bus goes idle and arbitration restarts.

Top module: `shared_bus_ctrl`

## Requirements
- R1: `m_gnt` is one-hot or all zero in every cycle, so at most one master owns the bus.
- R2: When the bus is idle (`bus_busy` low) and any request is high, a grant appears in the next cycle. `bus_busy` is high exactly while a grant is held.
- R3: Among masters requesting at an idle bus, the one with the lowest index (master 0 highest) receives the grant.
- R4: The grant stays with its owner for as long as the owner keeps its request high. A request from a higher-priority master in the meantime waits.
- R5: In the cycle after the owner lowers its request, grant and `bus_busy` are low. A pending request is granted one cycle after that.
- R6: While the owner's transfer is open, `bus_addr`, `bus_cmd` and `bus_wdata` carry the owner's values. `slv_sel` is one-hot on the slave numbered by `bus_addr[AW-1:AW-2]` if that slot is populated (default population mask 4'b0111, so slot 3 is empty) and zero otherwise. With no owner the bus lines are zero.
- R7: A response on `slv_ack` from the currently selected slave raises the owner's `m_ack` in the same cycle, with `m_rdata` equal to that slave's read data (zero otherwise). Responses from unselected slaves are ignored. After a response, `slv_sel` stays low until the owner releases the bus.
- R8: If no response arrives, the owner's `m_err` pulses in the fourth cycle after the grant's first cycle. After that, no slave is selected. A response that arrives in that same cycle wins, and no error is raised.
- R9: Under reset, all grants, selects, responses, errors and `bus_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | N_MST | Per-master bus request |
| m_addr | input | N_MST*AW | Per-master address, master i at bits [i*AW +: AW] |
| m_cmd | input | N_MST | Per-master command, 1 = write, 0 = read |
| m_wdata | input | N_MST*DW | Per-master write data |
| m_gnt | output | N_MST | One-hot bus grant |
| m_ack | output | N_MST | Transfer completed, to owner |
| m_err | output | N_MST | Transfer timed out, to owner |
| m_rdata | output | DW | Read data of the completing transfer |
| bus_busy | output | 1 | Bus owned |
| bus_addr | output | AW | Shared address |
| bus_cmd | output | 1 | Shared command |
| bus_wdata | output | DW | Shared write data |
| slv_sel | output | N_SLV | Per-slave select |
| slv_ack | input | N_SLV | Per-slave response |
| slv_rdata | input | N_SLV*DW | Per-slave read data, slave k at bits [k*DW +: DW] |

## Verification
The slave response and the timeout expiry can land in the same cycle. The bench provokes this by making a modelled slave answer exactly four cycles into the transfer. The result is judged by requiring `m_ack` high and `m_err` low in that cycle. A second coincidence is a higher-priority request arriving while a lower master owns the bus. There the bench expects the grant to stay put until the owner's release, and then to go to the higher master ahead of older waiters.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic {
      CMD_READ  = 1'b0,
      CMD_WRITE = 1'b1
   } bus_cmd_e;

   localparam int unsigned SBC_SEL_BITS = 2;
endpackage

// File: rtl/sbc_prio_arb.sv
module sbc_prio_arb #(
   parameter int unsigned N  = 4,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          vld,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign vld = |req;
endmodule

// File: rtl/sbc_addr_dec.sv
module sbc_addr_dec #(
   parameter int unsigned AW      = 16,
   parameter int unsigned N_SLV   = 4,
   parameter logic [N_SLV-1:0] PRESENT = '1,
   localparam int unsigned SW     = $clog2(N_SLV)
) (
   input  logic [AW-1:0]    addr,
   input  logic             en,
   output logic [N_SLV-1:0] sel,
   output logic [SW-1:0]    idx
);
   assign idx = addr[AW-1 -: SW];

   for (genvar k = 0; k < N_SLV; k++) begin : g_sel
      if (PRESENT[k]) begin : g_pop
         assign sel[k] = en && (idx == SW'(k));
      end else begin : g_empty
         assign sel[k] = 1'b0;
      end
   end
endmodule

// File: rtl/sbc_xfer_timer.sv
module sbc_xfer_timer #(
   parameter int unsigned TIMEOUT = 4,
   localparam int unsigned CW     = $clog2(TIMEOUT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (!run)                   cnt_q <= '0;
      else if (cnt_q != CW'(TIMEOUT))  cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == CW'(TIMEOUT));

   AST_EXPIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      expired |-> $past(run)) else $error("expiry without running window"); // R8
endmodule

// File: rtl/shared_bus_ctrl.sv
module shared_bus_ctrl #(
   parameter int unsigned N_MST   = 4,
   parameter int unsigned N_SLV   = 4,
   parameter int unsigned AW      = 16,
   parameter int unsigned DW      = 32,
   parameter int unsigned TIMEOUT = 4,
   parameter logic [N_SLV-1:0] SLV_PRESENT = 4'b0111
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MST-1:0]     m_req,
   input  logic [N_MST*AW-1:0]  m_addr,
   input  logic [N_MST-1:0]     m_cmd,
   input  logic [N_MST*DW-1:0]  m_wdata,
   output logic [N_MST-1:0]     m_gnt,
   output logic [N_MST-1:0]     m_ack,
   output logic [N_MST-1:0]     m_err,
   output logic [DW-1:0]        m_rdata,
   output logic                 bus_busy,
   output logic [AW-1:0]        bus_addr,
   output logic                 bus_cmd,
   output logic [DW-1:0]        bus_wdata,
   output logic [N_SLV-1:0]     slv_sel,
   input  logic [N_SLV-1:0]     slv_ack,
   input  logic [N_SLV*DW-1:0]  slv_rdata
);
   import sbc_pkg::*;

   localparam int unsigned IW = (N_MST > 1) ? $clog2(N_MST) : 1;
   localparam int unsigned SW = $clog2(N_SLV);

   if (N_SLV != (1 << sbc_pkg::SBC_SEL_BITS)) begin : g_chk_slv
      $error("N_SLV must match the two-bit slave field");
   end
   if (AW <= SW) begin : g_chk_aw
      $error("AW too narrow for slave field");
   end
   if (TIMEOUT < 1) begin : g_chk_to
      $error("TIMEOUT must be at least 1");
   end
   if (N_MST < 2) begin : g_chk_mst
      $error("need at least two masters");
   end

   logic          own_vld_q;
   logic [IW-1:0] own_idx_q;
   logic          done_q;

   logic          arb_vld;
   logic [IW-1:0] arb_idx;
   logic          own_req;
   logic          phase;
   logic [AW-1:0] own_addr;
   logic [SW-1:0] dec_idx;
   logic          resp_ok;
   logic          expired;
   logic          err_now;
   bus_cmd_e      own_cmd;

   sbc_prio_arb #(.N(N_MST)) u_arb (
      .req (m_req),
      .vld (arb_vld),
      .idx (arb_idx)
   );

   assign own_req  = m_req[own_idx_q];
   assign phase    = own_vld_q && !done_q;
   assign own_addr = m_addr[own_idx_q*AW +: AW];
   assign own_cmd  = bus_cmd_e'(m_cmd[own_idx_q]);

   sbc_addr_dec #(.AW(AW), .N_SLV(N_SLV), .PRESENT(SLV_PRESENT)) u_dec (
      .addr (own_addr),
      .en   (phase),
      .sel  (slv_sel),
      .idx  (dec_idx)
   );

   sbc_xfer_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (phase),
      .expired (expired)
   );

   assign resp_ok = |(slv_sel & slv_ack);
   assign err_now = expired && !resp_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_vld_q <= 1'b0;
         own_idx_q <= '0;
         done_q    <= 1'b0;
      end else if (!own_vld_q) begin
         if (arb_vld) begin
            own_vld_q <= 1'b1;
            own_idx_q <= arb_idx;
            done_q    <= 1'b0;
         end
      end else if (!own_req) begin
         own_vld_q <= 1'b0;
         done_q    <= 1'b0;
      end else if (resp_ok || err_now) begin
         done_q    <= 1'b1;
      end
   end

   for (genvar i = 0; i < N_MST; i++) begin : g_mst
      assign m_gnt[i] = own_vld_q && (own_idx_q == IW'(i));
      assign m_ack[i] = resp_ok   && (own_idx_q == IW'(i));
      assign m_err[i] = err_now   && (own_idx_q == IW'(i));
   end

   assign bus_busy  = own_vld_q;
   assign bus_addr  = own_vld_q ? own_addr : '0;
   assign bus_cmd   = own_vld_q && (own_cmd == CMD_WRITE);
   assign bus_wdata = own_vld_q ? m_wdata[own_idx_q*DW +: DW] : '0;
   assign m_rdata   = resp_ok ? slv_rdata[dec_idx*DW +: DW] : '0;

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_gnt)) else $error("grant not one-hot"); // R1
   AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_busy && |m_req) |=> (|m_gnt && bus_busy)) else $error("idle request not granted"); // R2
   AST_PRIO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_busy && m_req[0]) |=> m_gnt[0]) else $error("top master lost arbitration"); // R3
   AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (|(m_gnt & m_req)) |=> $stable(m_gnt)) else $error("grant moved while held"); // R4
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_busy && !(|(m_gnt & m_req))) |=> !bus_busy) else $error("bus kept after release"); // R5
   AST_SEL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (|slv_sel) |-> (bus_busy && $onehot(slv_sel))) else $error("select without owner"); // R6
   AST_ACK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (|m_ack) |=> (slv_sel == '0)) else $error("select after response"); // R7
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|m_err) |=> (m_err == '0 && slv_sel == '0)) else $error("error not a pulse"); // R8
endmodule

// File: tb/shared_bus_ctrl_tb.sv
module shared_bus_ctrl_tb;
   localparam int NM = 4, NS = 4, AW = 16, DW = 32, TO = 4;
   localparam logic [NS-1:0] PRES = 4'b0111;

   logic clk = 0, rst_n = 0;
   logic [NM-1:0] m_req = '0, m_cmd = '0;
   logic [NM*AW-1:0] m_addr = '0;
   logic [NM*DW-1:0] m_wdata = '0;
   logic [NM-1:0] m_gnt, m_ack, m_err;
   logic [DW-1:0] m_rdata, bus_wdata;
   logic bus_busy, bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [NS-1:0] slv_sel, slv_ack = '0;
   logic [NS*DW-1:0] slv_rdata;

   always #5 clk = ~clk;

   shared_bus_ctrl #(.N_MST(NM), .N_SLV(NS), .AW(AW), .DW(DW), .TIMEOUT(TO),
                     .SLV_PRESENT(PRES)) u_dut (.*);

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit pend [NM];
   logic [AW-1:0] ma [NM];
   logic [DW-1:0] md [NM];
   bit mc [NM];
   int own = -1, cnt = 0, sdly = 1;
   bit done = 0;
   logic [NS-1:0] spur = '0;

   initial for (int k = 0; k < NS; k++) slv_rdata[k*DW +: DW] = 32'hA5000000 + 32'(k * 17);

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   task automatic post(int i, logic [AW-1:0] a, bit c, logic [DW-1:0] d);
      pend[i] = 1; ma[i] = a; mc[i] = c; md[i] = d;
   endtask

   task automatic step();
      logic [NM-1:0] req_now;
      int k;
      bit ph, hit, ackn, errn;
      @(negedge clk);
      req_now = '0;
      for (int i = 0; i < NM; i++) begin
         req_now[i] = pend[i];
         m_addr[i*AW +: AW] = ma[i];
         m_wdata[i*DW +: DW] = md[i];
         m_cmd[i] = mc[i];
      end
      m_req = req_now;
      ph = (own >= 0) && !done;
      k = (own >= 0) ? int'(ma[own][AW-1 -: 2]) : 0;
      hit = ph && PRES[k];
      slv_ack = spur;
      if (hit && cnt == sdly) slv_ack[k] = 1'b1;
      ackn = hit && slv_ack[k];
      errn = ph && !ackn && (cnt == TO);
      #1;
      chk("R1 gnt", 64'(m_gnt), (own >= 0) ? 64'(1) << own : 64'(0));
      chk("R2 busy", 64'(bus_busy), 64'(own >= 0));
      chk("R6 sel", 64'(slv_sel), hit ? 64'(1) << k : 64'(0));
      chk("R6 addr", 64'(bus_addr), (own >= 0) ? 64'(ma[own]) : 64'(0));
      chk("R6 cmd", 64'(bus_cmd), (own >= 0) ? 64'(mc[own]) : 64'(0));
      chk("R6 wdata", 64'(bus_wdata), (own >= 0) ? 64'(md[own]) : 64'(0));
      chk("R7 ack", 64'(m_ack), ackn ? 64'(1) << own : 64'(0));
      chk("R7 rdata", 64'(m_rdata), ackn ? 64'(slv_rdata[k*DW +: DW]) : 64'(0));
      chk("R8 err", 64'(m_err), errn ? 64'(1) << own : 64'(0));
      @(posedge clk);
      cyc++;
      if (own < 0) begin
         for (int i = NM - 1; i >= 0; i--) if (req_now[i]) own = i;
         done = 0; cnt = 0;
      end else if (!req_now[own]) begin
         own = -1; done = 0; cnt = 0;
      end else begin
         if (ackn || errn) begin done = 1; pend[own] = 0; end
         if (ph && cnt < TO) cnt++;
         else if (!ph) cnt = 0;
      end
   endtask

   task automatic drain();
      bit busy;
      do begin
         step();
         busy = (own >= 0);
         for (int i = 0; i < NM; i++) busy |= pend[i];
      end while (busy);
   endtask

   initial begin
      for (int i = 0; i < NM; i++) begin pend[i] = 0; ma[i] = '0; md[i] = '0; mc[i] = 0; end
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R9 reset gnt", 64'(m_gnt), 0);
      chk("R9 reset busy", 64'(bus_busy), 0);
      chk("R9 reset sel", 64'(slv_sel), 0);
      chk("R9 reset resp", 64'({m_ack, m_err}), 0);
      rst_n = 1;
      // R2 R6 R7: one master writes slave 1
      post(2, 16'h4010, 1, 32'h11112222);
      drain();
      // R3 R4 R5: simultaneous requests, then top master arrives mid-transfer
      post(1, 16'h0020, 0, 32'h1);
      post(2, 16'h4030, 1, 32'h2);
      post(3, 16'h8040, 1, 32'h3);
      step(); step();
      post(0, 16'h8050, 0, 32'h4);
      drain();
      // R8: empty slot times out
      post(3, 16'hC000, 1, 32'h5);
      drain();
      // R8: response exactly at timeout cycle wins
      sdly = 4;
      post(0, 16'h0100, 0, 32'h6);
      drain();
      // R8: populated but silent slave times out
      sdly = 7;
      post(1, 16'h8200, 1, 32'h7);
      drain();
      // R7: response from an unselected slave is ignored
      sdly = 1; spur = 4'b0100;
      post(0, 16'h0004, 0, 32'h8);
      drain();
      spur = '0;
      repeat (3) step();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule